// File: doc/BRIEF.md
# Halt-Mode Auto-Wakeup Timer Controller

This block lets a small processor core sleep in a low-power halt state and wake itself after a programmable delay. Software first sets a wakeup-enable bit and loads an 8-bit prescaler. It then issues a halt request. The block stops the main oscillator and counts a separate slow clock. The slow clock passes first through a fixed divider (parameter `DIV`, default 64) and then through the prescaler.

When the count expires, the block sets a wakeup flag and raises an interrupt request. It turns the main oscillator back on at once and holds the CPU stalled for an oscillator settling time of 256 or 4096 main-clock cycles. The flag and the interrupt clear as a side effect of reading the control/status register. Any other wake-capable interrupt also ends the halt, as does a reset.

For calibration, a measurement bit routes the slow clock, resynchronised into the main domain, to a timer capture output while the core is running. Software can then time the slow clock against the main clock and choose a prescaler value.

Top module: `awu_ctrl`

## Requirements
- R1: A `halt_req` pulse enters the auto-wakeup halt state only when control bit 0 (enable) is 1 and `clkout_irq_en` is 0. On the next cycle `halted` is 1, `cpu_run` is 0 and `main_osc_en` is 0. Under any other condition the request is ignored and `cpu_run` stays 1.
- R2: The wakeup delay is `DIV` × P slow-clock periods, plus a few cycles of synchroniser latency. P is the value in the prescaler register (address 1), and a value of 0 acts as 1.
- R3: On expiry, control bit 2 (flag) and `awu_irq` go to 1 and the halt state ends.
- R4: When the halt ends, `main_osc_en` rises on the same edge that clears `halted`. `cpu_run` rises exactly 256 clock cycles later when control bit 3 is 0, and exactly 4096 cycles later when it is 1.
- R5: A read of the control register (address 0) returns the flag in bit 2 and then clears the flag and `awu_irq`. If the read falls in the same cycle as a new expiry, the flag is left set.
- R6: Entry to the halt state pulses `mask_load` for one cycle, with `mask_value` = 2'b10. If `wake_irq` is already high at entry, the halt ends on the following cycle.
- R7: While running with control bit 1 (measure) set, `capture_out` follows the slow clock, at one rising edge per slow period. It is 0 when the bit is clear and whenever the core is not running.
- R8: `wake_irq` ends the halt without setting the flag. A reset during the halt returns the block to the running state.
- R9: After reset, both registers read 0. `cpu_run` and `main_osc_en` are 1, and `halted`, `awu_irq` and `capture_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset, held for several slow periods |
| slow_clk | input | 1 | Slow wakeup oscillator clock |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0: control/status, 1: prescaler |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| halt_req | input | 1 | Halt request pulse from the core |
| clkout_irq_en | input | 1 | Main-clock output interrupt enable; blocks auto-wakeup halt |
| wake_irq | input | 1 | Any other wake-capable interrupt pending |
| halted | output | 1 | Auto-wakeup halt state active |
| main_osc_en | output | 1 | Main oscillator enable |
| cpu_run | output | 1 | CPU released |
| awu_irq | output | 1 | Wakeup interrupt request |
| mask_load | output | 1 | One-cycle pulse forcing the core's interrupt mask |
| mask_value | output | 2 | Mask value to load |
| capture_out | output | 1 | Slow clock to the timer capture input |

## Verification
The assertions assume three things about the inputs. `rst` is held long enough for the slow domain to see it. The prescaler register is not written while `halted` is 1. `halt_req` is a single-cycle pulse. The stimulus meets these by doing every register write while running and by holding reset for thirty main cycles. It keeps the slow clock at ten main-clock periods, so expected delays can be bounded in main cycles. Random prescaler values, settling selections and early wake interrupts are drawn only between complete halt sequences, and each sequence waits for `cpu_run` to return before the next one starts.

// File: rtl/awu_pkg.sv
package awu_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STAB = 2'd2
  } awu_state_e;

  localparam int CTL_EN   = 0;
  localparam int CTL_MEAS = 1;
  localparam int CTL_FLAG = 2;
  localparam int CTL_LONG = 3;

  localparam logic ADDR_CTL = 1'b0;
  localparam logic ADDR_PSC = 1'b1;

  localparam logic [1:0] HALT_MASK = 2'b10;
endpackage

// File: rtl/awu_sync.sv
module awu_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/awu_slow_cnt.sv
module awu_slow_cnt #(
  parameter int DIV   = 64,
  parameter int PSC_W = 8
) (
  input  logic             slow_clk,
  input  logic             rst,
  input  logic             run_s,
  input  logic [PSC_W-1:0] psc,
  output logic             exp_tog
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DIV_M1 = DW'(DIV - 1);

  logic [DW-1:0]    div_cnt;
  logic [PSC_W-1:0] psc_cnt;
  logic [PSC_W:0]   psc_eff;
  logic [PSC_W:0]   psc_nxt;
  logic             fired;

  assign psc_eff = (psc == '0) ? (PSC_W+1)'(1) : {1'b0, psc};
  assign psc_nxt = {1'b0, psc_cnt} + 1'b1;

  always_ff @(posedge slow_clk) begin
    if (rst) begin
      div_cnt <= '0;
      psc_cnt <= '0;
      fired   <= 1'b0;
      exp_tog <= 1'b0;
    end else if (!run_s) begin
      div_cnt <= '0;
      psc_cnt <= '0;
      fired   <= 1'b0;
    end else if (!fired) begin
      if (div_cnt == DIV_M1) begin
        div_cnt <= '0;
        if (psc_nxt == psc_eff) begin
          fired   <= 1'b1;
          exp_tog <= ~exp_tog;
        end else begin
          psc_cnt <= psc_cnt + 1'b1;
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  AST_PSC_IN_RANGE: assert property (@(posedge slow_clk) disable iff (rst)
    {1'b0, psc_cnt} < psc_eff); // R2
  AST_IDLE_CLEAR: assert property (@(posedge slow_clk) disable iff (rst)
    !run_s |=> (div_cnt == '0 && !fired)); // R2
endmodule

// File: rtl/awu_stab_timer.sv
module awu_stab_timer #(
  parameter int STAB_SHORT = 256,
  parameter int STAB_LONG  = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic long_sel,
  output logic done
);
  localparam int CW = $clog2(STAB_LONG);
  localparam logic [CW-1:0] SHORT_M1 = CW'(STAB_SHORT - 1);
  localparam logic [CW-1:0] LONG_M1  = CW'(STAB_LONG - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = long_sel ? LONG_M1 : SHORT_M1;
  assign done  = active && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !active) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  AST_STAB_BOUND: assert property (@(posedge clk) disable iff (rst)
    active |-> cnt <= limit); // R4
endmodule

// File: rtl/awu_ctrl.sv
module awu_ctrl
  import awu_pkg::*;
#(
  parameter int DIV        = 64,
  parameter int PSC_W      = 8,
  parameter int STAB_SHORT = 256,
  parameter int STAB_LONG  = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slow_clk,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             halt_req,
  input  logic             clkout_irq_en,
  input  logic             wake_irq,
  output logic             halted,
  output logic             main_osc_en,
  output logic             cpu_run,
  output logic             awu_irq,
  output logic             mask_load,
  output logic [1:0]       mask_value,
  output logic             capture_out
);
  awu_state_e state_q, state_d;

  logic             ctl_en, ctl_meas, ctl_long, flag;
  logic [PSC_W-1:0] psc_q;
  logic             run_s;
  logic             exp_tog;
  logic [1:0]       sync_q;
  logic             tog_prev;
  logic             exp_pulse;
  logic             set_evt;
  logic             rd_ctl;
  logic             stab_done;
  logic             unused_wbits;

  assign unused_wbits = ^{reg_wdata[7:4], reg_wdata[CTL_FLAG]};

  // slow-domain copy of the halt state
  awu_sync #(.W(1)) u_run_sync (
    .clk (slow_clk),
    .rst (rst),
    .d   (halted),
    .q   (run_s)
  );

  awu_slow_cnt #(.DIV(DIV), .PSC_W(PSC_W)) u_slow (
    .slow_clk (slow_clk),
    .rst      (rst),
    .run_s    (run_s),
    .psc      (psc_q),
    .exp_tog  (exp_tog)
  );

  // expiry toggle and slow clock brought into the main domain
  awu_sync #(.W(2)) u_main_sync (
    .clk (clk),
    .rst (rst),
    .d   ({slow_clk, exp_tog}),
    .q   (sync_q)
  );

  always_ff @(posedge clk) begin
    if (rst) tog_prev <= 1'b0;
    else     tog_prev <= sync_q[0];
  end

  assign exp_pulse = sync_q[0] ^ tog_prev;
  assign set_evt   = exp_pulse && (state_q == ST_HALT);
  assign rd_ctl    = reg_rd && (reg_addr == ADDR_CTL);

  awu_stab_timer #(.STAB_SHORT(STAB_SHORT), .STAB_LONG(STAB_LONG)) u_stab (
    .clk      (clk),
    .rst      (rst),
    .active   (state_q == ST_STAB),
    .long_sel (ctl_long),
    .done     (stab_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (halt_req && ctl_en && !clkout_irq_en) state_d = ST_HALT;
      ST_HALT: if (wake_irq || exp_pulse)               state_d = ST_STAB;
      ST_STAB: if (stab_done)                           state_d = ST_RUN;
      default:                                          state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_RUN;
      halted      <= 1'b0;
      cpu_run     <= 1'b1;
      main_osc_en <= 1'b1;
      mask_load   <= 1'b0;
      mask_value  <= 2'b00;
      capture_out <= 1'b0;
    end else begin
      state_q     <= state_d;
      halted      <= (state_d == ST_HALT);
      cpu_run     <= (state_d == ST_RUN);
      main_osc_en <= (state_d != ST_HALT);
      mask_load   <= (state_q == ST_RUN) && (state_d == ST_HALT);
      mask_value  <= ((state_q == ST_RUN) && (state_d == ST_HALT)) ? HALT_MASK : 2'b00;
      capture_out <= ctl_meas && (state_d == ST_RUN) && sync_q[1];
    end
  end

  // registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en    <= 1'b0;
      ctl_meas  <= 1'b0;
      ctl_long  <= 1'b0;
      flag      <= 1'b0;
      psc_q     <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CTL) begin
        ctl_en   <= reg_wdata[CTL_EN];
        ctl_meas <= reg_wdata[CTL_MEAS];
        ctl_long <= reg_wdata[CTL_LONG];
      end
      if (reg_wr && reg_addr == ADDR_PSC) psc_q <= reg_wdata[PSC_W-1:0];
      if (set_evt)     flag <= 1'b1;
      else if (rd_ctl) flag <= 1'b0;
      if (reg_rd) begin
        if (reg_addr == ADDR_CTL) begin
          reg_rdata <= '0;
          reg_rdata[CTL_EN]   <= ctl_en;
          reg_rdata[CTL_MEAS] <= ctl_meas;
          reg_rdata[CTL_FLAG] <= flag;
          reg_rdata[CTL_LONG] <= ctl_long;
        end else begin
          reg_rdata <= 8'(psc_q);
        end
      end
    end
  end

  assign awu_irq = flag;

  AST_ENTRY_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && (clkout_irq_en || !ctl_en)) |=> !halted); // R1
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> (awu_irq && !halted)); // R3
  AST_OSC_AT_WAKE: assert property (@(posedge clk) disable iff (rst)
    $fell(halted) |-> main_osc_en); // R4
  AST_HELD_IN_STAB: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STAB) |-> !cpu_run); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_ctl && !set_evt) |=> !awu_irq); // R5
  AST_MASK_PULSE: assert property (@(posedge clk) disable iff (rst)
    mask_load |-> (mask_value == HALT_MASK && halted)); // R6
  AST_MASK_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    mask_load |=> !mask_load); // R6
  AST_CAPTURE_RUN_ONLY: assert property (@(posedge clk) disable iff (rst)
    capture_out |-> cpu_run); // R7
  AST_WAKE_EXITS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HALT && wake_irq) |=> !halted); // R8
  AST_ONE_STATE: assert property (@(posedge clk) disable iff (rst)
    $countones({halted, cpu_run}) <= 1); // R4
endmodule

// File: tb/sim_awu_ctrl.sv
`timescale 1ns/1ps
module sim_awu_ctrl;
  localparam int DIV_P = 4;
  localparam int SLOW_RATIO = 10;

  logic clk = 1'b0, slow_clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0, reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic halt_req = 0, clkout_irq_en = 0, wake_irq = 0;
  logic halted, main_osc_en, cpu_run, awu_irq, mask_load, capture_out;
  logic [1:0] mask_value;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always #25  slow_clk = ~slow_clk;
  always @(posedge clk) cyc <= cyc + 1;

  awu_ctrl #(.DIV(DIV_P)) u0 (
    .clk(clk), .rst(rst), .slow_clk(slow_clk),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .halt_req(halt_req), .clkout_irq_en(clkout_irq_en), .wake_irq(wake_irq),
    .halted(halted), .main_osc_en(main_osc_en), .cpu_run(cpu_run),
    .awu_irq(awu_irq), .mask_load(mask_load), .mask_value(mask_value),
    .capture_out(capture_out)
  );

  function automatic int exp_delay(input int psc);
    return DIV_P * ((psc == 0) ? 1 : psc) * SLOW_RATIO;
  endfunction

  function automatic int exp_stab(input bit long_sel);
    return long_sel ? 4096 : 256;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input bit a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  // one full halt sequence; early < 0 means no wake_irq
  task automatic run_halt(input int psc, input bit long_sel, input bit meas, input int early);
    logic [7:0] d;
    int hl, k, caps;
    wr(1'b1, 8'(psc));
    wr(1'b0, {4'b0, long_sel, 1'b0, meas, 1'b1});
    @(negedge clk);
    halt_req = 1;
    @(negedge clk);
    halt_req = 0;
    chk(halted === 1'b1 && cpu_run === 1'b0 && main_osc_en === 1'b0, "R1 entry", halted, 1);
    chk(mask_load === 1'b1 && mask_value === 2'b10, "R6 mask", mask_value, 2);
    hl = 0; caps = 0;
    while (halted === 1'b1) begin
      hl++;
      if (capture_out !== 1'b0) caps++;
      if (early >= 0 && hl == early) wake_irq = 1;
      @(negedge clk);
    end
    wake_irq = 0;
    chk(caps == 0, "R7 capture off in halt", caps, 0);
    chk(main_osc_en === 1'b1, "R4 osc on at wake", main_osc_en, 1);
    if (early < 0) begin
      chk(hl >= exp_delay(psc) && hl <= exp_delay(psc) + 60, "R2 delay", hl, exp_delay(psc));
      chk(awu_irq === 1'b1, "R3 irq set", awu_irq, 1);
    end else begin
      chk(hl <= early + 2, "R8 wake exit", hl, early);
      chk(awu_irq === 1'b0, "R8 no flag", awu_irq, 0);
    end
    k = 0;
    while (cpu_run !== 1'b1) begin
      k++;
      @(negedge clk);
    end
    chk(k == exp_stab(long_sel), "R4 settle", k, exp_stab(long_sel));
    rd(1'b0, d);
    chk(d[2] == (early < 0), "R5 flag read", d[2], early < 0);
    @(negedge clk);
    chk(awu_irq === 1'b0, "R5 cleared", awu_irq, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("[TB] FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    int rises, hl;
    void'($urandom(32'h1234_5EED));
    repeat (30) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk(cpu_run === 1 && main_osc_en === 1 && halted === 0, "R9 outputs", cpu_run, 1);
    chk(awu_irq === 0 && capture_out === 0, "R9 irq/capture", awu_irq, 0);
    rd(1'b0, d); chk(d == 8'h00, "R9 ctl", d, 0);
    rd(1'b1, d); chk(d == 8'h00, "R9 psc", d, 0);

    // R1 ignored requests
    @(negedge clk); halt_req = 1; @(negedge clk); halt_req = 0;
    chk(halted === 0 && cpu_run === 1, "R1 disabled", halted, 0);
    wr(1'b0, 8'h01); clkout_irq_en = 1;
    @(negedge clk); halt_req = 1; @(negedge clk); halt_req = 0;
    chk(halted === 0 && cpu_run === 1, "R1 clkout blocks", halted, 0);
    clkout_irq_en = 0;

    // R2/R3/R4 directed
    run_halt(0, 1'b0, 1'b0, -1);
    run_halt(1, 1'b0, 1'b0, -1);
    run_halt(3, 1'b1, 1'b0, -1);
    run_halt(7, 1'b0, 1'b1, -1);
    // R8 early wake
    run_halt(10, 1'b0, 1'b0, 5);

    // R6 pending interrupt at entry
    wr(1'b0, 8'h01);
    @(negedge clk); wake_irq = 1; halt_req = 1;
    @(negedge clk); halt_req = 0;
    chk(halted === 1 && mask_load === 1, "R6 entry", halted, 1);
    @(negedge clk); wake_irq = 0;
    chk(halted === 0 && main_osc_en === 1, "R6 immediate wake", halted, 0);
    while (cpu_run !== 1'b1) @(negedge clk);

    // R5 read coinciding with expiry
    wr(1'b1, 8'd2); wr(1'b0, 8'h01);
    @(negedge clk); halt_req = 1;
    @(negedge clk); halt_req = 0; reg_rd = 1; reg_addr = 0;
    while (halted === 1'b1) @(negedge clk);
    reg_rd = 0;
    chk(awu_irq === 1'b1, "R5 read vs expiry", awu_irq, 1);
    while (cpu_run !== 1'b1) @(negedge clk);
    rd(1'b0, d); chk(d[2] == 1'b1, "R5 flag kept", d[2], 1);
    @(negedge clk); chk(awu_irq === 0, "R5 later clear", awu_irq, 1'b0);

    // R8 reset during halt
    wr(1'b1, 8'd20); wr(1'b0, 8'h01);
    @(negedge clk); halt_req = 1; @(negedge clk); halt_req = 0;
    repeat (50) @(negedge clk);
    hl = halted;
    rst = 1; repeat (30) @(negedge clk); rst = 0; @(negedge clk);
    chk(hl == 1 && halted === 0 && cpu_run === 1, "R8 reset exit", cpu_run, 1);

    // R7 measurement
    wr(1'b0, 8'h02);
    rises = 0;
    @(negedge clk);
    for (int i = 0; i < 400; i++) begin
      logic p;
      p = capture_out;
      @(negedge clk);
      if (!p && capture_out) rises++;
    end
    chk(rises >= 38 && rises <= 42, "R7 follows slow clk", rises, 40);
    wr(1'b0, 8'h00);
    rises = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (capture_out) rises++;
    end
    chk(rises == 0, "R7 off when clear", rises, 0);

    // random sequences
    for (int it = 0; it < 20; it++) begin
      int psc, early;
      bit lng, ms;
      psc = $urandom_range(0, 12);
      lng = ($urandom_range(0, 4) == 0);
      ms = $urandom_range(0, 1);
      early = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 10) : -1;
      run_halt(psc, lng, ms, early);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule